// File: doc/BRIEF.md
# Fetch-Execute Sequencer with Interrupt Check

This block is the control sequencer of a small accumulator machine. It keeps a program counter, an instruction register, an accumulator and a single-slot context store. It walks every instruction through the same phases. First it reads the instruction word from synchronous memory. It then executes that word, which may need a second memory read or a memory write. Finally it spends one cycle checking for an interrupt before the next fetch begins. The memory port is a plain synchronous one: an address, a read strobe, a write strobe, write data and read data. Read data arrives one cycle after the cycle that carries the read strobe.

One interrupt request line is sampled together with an enable input, and the request is taken only in the interrupt-check phase. When a request is taken, the sequencer copies the program counter and the accumulator into the context store. It then moves the program counter to a fixed handler address and marks itself as being in the handler. Further requests are ignored until the handler ends with a return instruction. The return reloads both saved values in one cycle and clears the handler mark, so the interrupted program carries on as if nothing had happened.

Top module: `fx_sequencer`

## Requirements
- R1: While reset (active low) is held, the program counter and the accumulator are 0, the handler mark is low and no write strobe is driven. In the first cycle after reset is released, the block drives a read strobe with address 0.
- R2: A read takes two cycles: one cycle carries the strobe and the address, and the data is used in the next cycle. A read strobe is never driven in two consecutive cycles, and the read and write strobes are never high together.
- R3: Each fetch loads the addressed word into the instruction register and adds one to the program counter.
- R4: The instruction word holds the opcode in bits [15:13] and the operand address in bits [7:0]. Opcode 1 loads the accumulator from memory at the operand address, and opcode 3 adds that memory word to the accumulator (modulo 2^16). The new accumulator value appears two cycles after the operand read strobe.
- R5: Opcode 2 writes the accumulator to memory at the operand address in a single cycle.
- R6: Opcode 4 sets the program counter to the operand address, so the next fetch is taken from there.
- R7: Opcode 0 and the unused codes 6 and 7 change neither the accumulator nor memory, and execution goes on with the next word.
- R8: The interrupt-check phase follows every execute phase. If `irq_i` and `irq_en_i` are both high there and the handler mark is low, the program counter and accumulator are saved, the program counter becomes `ISR_ADDR` (default 0x40) and the handler mark rises. Otherwise the next fetch follows.
- R9: While the handler mark is high, requests are not taken and the saved context does not change, so the handler runs once per accepted request.
- R10: Opcode 5 (return) restores the saved program counter and accumulator in one cycle and clears the handler mark. The interrupted program then produces exactly the results it would have produced without the interrupt.
- R11: With `irq_en_i` low, a request on `irq_i` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_i | input | 1 | Interrupt request |
| irq_en_i | input | 1 | Interrupt enable |
| mem_addr_o | output | 8 | Memory address |
| mem_rd_o | output | 1 | Memory read strobe |
| mem_wr_o | output | 1 | Memory write strobe |
| mem_wdata_o | output | 16 | Memory write data |
| mem_rdata_i | input | 16 | Memory read data, valid one cycle after the read strobe |
| pc_o | output | 8 | Program counter |
| acc_o | output | 16 | Accumulator |
| in_handler_o | output | 1 | High while the interrupt handler runs |

## Verification
Several properties are checked on every cycle:
- the read strobe is followed by a data cycle and the two strobes never overlap;
- the program counter steps by one after each fetch;
- handler entry lands on the vector, with the context copied from the state that was live at the check phase;
- the context stays frozen while the handler runs;
- leaving the handler restores exactly the saved values;
- a disabled request never raises the handler mark.

Only the bench's program scenarios can show the remaining behaviours. These are that the arithmetic results stored to memory are correct, that a jump really skips code, and that a no-operation word leaves results alone. They also include that an interrupt arriving at any point of the program leaves the main results unchanged, and that a request held high during the handler still produces exactly one handler run.

// File: rtl/seq_pkg.sv
package seq_pkg;

    localparam int unsigned OPW = 3;

    typedef enum logic [2:0] {
        S_FREQ  = 3'd0,
        S_FWAIT = 3'd1,
        S_EXEC  = 3'd2,
        S_EWAIT = 3'd3,
        S_ICHK  = 3'd4
    } seq_state_e;

    typedef enum logic [OPW-1:0] {
        OP_NOP   = 3'd0,
        OP_LOAD  = 3'd1,
        OP_STORE = 3'd2,
        OP_ADD   = 3'd3,
        OP_JUMP  = 3'd4,
        OP_RET   = 3'd5
    } seq_op_e;

endpackage

// File: rtl/seq_decode.sv
module seq_decode
    import seq_pkg::*;
#(
    parameter int unsigned DW = 16,
    parameter int unsigned AW = 8
) (
    input  logic [DW-1:0] ir_i,
    output logic [AW-1:0] operand_o,
    output logic          is_load_o,
    output logic          is_store_o,
    output logic          is_add_o,
    output logic          is_jump_o,
    output logic          is_ret_o
);
    localparam int unsigned GAP_LO = AW;
    localparam int unsigned GAP_HI = DW - OPW - 1;

    logic [OPW-1:0] opcode;
    logic           unused_gap;

    assign opcode     = ir_i[DW-1 -: OPW];
    assign operand_o  = ir_i[AW-1:0];
    assign unused_gap = ^ir_i[GAP_HI:GAP_LO];

    always_comb begin
        is_load_o  = (opcode == OP_LOAD);
        is_store_o = (opcode == OP_STORE);
        is_add_o   = (opcode == OP_ADD);
        is_jump_o  = (opcode == OP_JUMP);
        is_ret_o   = (opcode == OP_RET);
    end
endmodule

// File: rtl/seq_alu.sv
module seq_alu #(
    parameter int unsigned DW = 16
) (
    input  logic [DW-1:0] acc_i,
    input  logic [DW-1:0] mem_i,
    input  logic          add_i,
    output logic [DW-1:0] res_o
);
    always_comb begin
        if (add_i) res_o = acc_i + mem_i;
        else       res_o = mem_i;
    end
endmodule

// File: rtl/seq_ctx.sv
module seq_ctx #(
    parameter int unsigned DW = 16,
    parameter int unsigned AW = 8
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          save_i,
    input  logic [AW-1:0] pc_i,
    input  logic [DW-1:0] acc_i,
    output logic [AW-1:0] pc_o,
    output logic [DW-1:0] acc_o
);
    typedef struct packed {
        logic [AW-1:0] pc;
        logic [DW-1:0] acc;
    } ctx_s;

    ctx_s ctx_d, ctx_q;

    always_comb begin
        ctx_d = ctx_q;
        if (save_i) begin
            ctx_d.pc  = pc_i;
            ctx_d.acc = acc_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) ctx_q <= '0;
        else         ctx_q <= ctx_d;
    end

    assign pc_o  = ctx_q.pc;
    assign acc_o = ctx_q.acc;
endmodule

// File: rtl/fx_sequencer.sv
module fx_sequencer
    import seq_pkg::*;
#(
    parameter int unsigned DW       = 16,
    parameter int unsigned AW       = 8,
    parameter int unsigned ISR_ADDR = 64
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          irq_i,
    input  logic          irq_en_i,
    output logic [AW-1:0] mem_addr_o,
    output logic          mem_rd_o,
    output logic          mem_wr_o,
    output logic [DW-1:0] mem_wdata_o,
    input  logic [DW-1:0] mem_rdata_i,
    output logic [AW-1:0] pc_o,
    output logic [DW-1:0] acc_o,
    output logic          in_handler_o
);
    localparam logic [AW-1:0] ISR_VEC = AW'(ISR_ADDR);

    typedef struct packed {
        seq_state_e    st;
        logic [AW-1:0] pc;
        logic [DW-1:0] ir;
        logic [DW-1:0] acc;
        logic          in_isr;
    } core_s;

    core_s core_d, core_q;

    logic [AW-1:0] operand;
    logic          is_load, is_store, is_add, is_jump, is_ret;
    logic [DW-1:0] alu_res;
    logic          ctx_save;
    logic [AW-1:0] ctx_pc;
    logic [DW-1:0] ctx_acc;

    seq_decode #(.DW(DW), .AW(AW)) u_decode (
        .ir_i       (core_q.ir),
        .operand_o  (operand),
        .is_load_o  (is_load),
        .is_store_o (is_store),
        .is_add_o   (is_add),
        .is_jump_o  (is_jump),
        .is_ret_o   (is_ret)
    );

    seq_alu #(.DW(DW)) u_alu (
        .acc_i (core_q.acc),
        .mem_i (mem_rdata_i),
        .add_i (is_add),
        .res_o (alu_res)
    );

    seq_ctx #(.DW(DW), .AW(AW)) u_ctx (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .save_i (ctx_save),
        .pc_i   (core_q.pc),
        .acc_i  (core_q.acc),
        .pc_o   (ctx_pc),
        .acc_o  (ctx_acc)
    );

    always_comb begin
        core_d      = core_q;
        mem_rd_o    = 1'b0;
        mem_wr_o    = 1'b0;
        mem_addr_o  = core_q.pc;
        mem_wdata_o = core_q.acc;
        ctx_save    = 1'b0;
        unique case (core_q.st)
            S_FREQ: begin
                mem_rd_o  = 1'b1;
                core_d.st = S_FWAIT;
            end
            S_FWAIT: begin
                core_d.ir = mem_rdata_i;
                core_d.pc = core_q.pc + 1'b1;
                core_d.st = S_EXEC;
            end
            S_EXEC: begin
                core_d.st = S_ICHK;
                if (is_load || is_add) begin
                    mem_rd_o   = 1'b1;
                    mem_addr_o = operand;
                    core_d.st  = S_EWAIT;
                end else if (is_store) begin
                    mem_wr_o   = 1'b1;
                    mem_addr_o = operand;
                end else if (is_jump) begin
                    core_d.pc = operand;
                end else if (is_ret) begin
                    core_d.pc     = ctx_pc;
                    core_d.acc    = ctx_acc;
                    core_d.in_isr = 1'b0;
                end
            end
            S_EWAIT: begin
                core_d.acc = alu_res;
                core_d.st  = S_ICHK;
            end
            S_ICHK: begin
                core_d.st = S_FREQ;
                if (irq_i && irq_en_i && !core_q.in_isr) begin
                    ctx_save      = 1'b1;
                    core_d.pc     = ISR_VEC;
                    core_d.in_isr = 1'b1;
                end
            end
            default: core_d.st = S_FREQ;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            core_q    <= '0;
            core_q.st <= S_FREQ;
        end else begin
            core_q <= core_d;
        end
    end

    assign pc_o         = core_q.pc;
    assign acc_o        = core_q.acc;
    assign in_handler_o = core_q.in_isr;

    AST_STROBE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(mem_rd_o && mem_wr_o)); // R2
    AST_READ_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        mem_rd_o |=> !mem_rd_o); // R2
    AST_PC_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (core_q.st == S_FWAIT) |=> (core_q.pc == $past(core_q.pc) + 1'b1)); // R3
    AST_ENTRY_SAVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(core_q.in_isr) |-> (core_q.pc == ISR_VEC && ctx_pc == $past(core_q.pc)
                                  && ctx_acc == $past(core_q.acc))); // R8
    AST_NO_REENTRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (core_q.in_isr && core_q.st == S_ICHK) |=> (core_q.in_isr && $stable(ctx_pc)
                                                     && $stable(ctx_acc))); // R9
    AST_RESTORE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(core_q.in_isr) |-> (core_q.pc == ctx_pc && core_q.acc == ctx_acc)); // R10
    AST_MASKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (core_q.st == S_ICHK && !irq_en_i) |=> $stable(core_q.in_isr)); // R11
endmodule

// File: tb/fx_sequencer_bench.sv
`timescale 1ns/1ps
module fx_sequencer_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        irq = 1'b0;
    logic        irq_en = 1'b0;
    logic [7:0]  mem_addr;
    logic        mem_rd, mem_wr;
    logic [15:0] mem_wdata;
    logic [15:0] mem_rdata = '0;
    logic [7:0]  pc;
    logic [15:0] acc;
    logic        in_h;

    logic [15:0] mem [256];
    int checks = 0;
    int failures = 0;
    int cycles = 0;
    logic done = 1'b0;

    always #2 clk = ~clk;

    fx_sequencer u_fx_sequencer (
        .clk_i(clk), .rst_ni(rst_n), .irq_i(irq), .irq_en_i(irq_en),
        .mem_addr_o(mem_addr), .mem_rd_o(mem_rd), .mem_wr_o(mem_wr),
        .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata),
        .pc_o(pc), .acc_o(acc), .in_handler_o(in_h)
    );

    always @(posedge clk) begin
        if (mem_rd) mem_rdata <= mem[mem_addr];
        if (mem_wr) mem[mem_addr] <= mem_wdata;
    end

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000 && !done) begin
            failures = failures + 1;
            $display("FAIL watchdog: actual=%0d cycles expected<=150000", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    function automatic logic [15:0] ins(input logic [2:0] op, input logic [7:0] a);
        return {op, 5'b0, a};
    endfunction
    function automatic logic [15:0] exp_sum3(input logic [15:0] a, b, c);
        return a + b + c;
    endfunction
    function automatic logic [15:0] exp_double(input logic [15:0] x);
        return x + x;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks = checks + 1;
        if (act !== exp) begin
            failures = failures + 1;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic load_prog(input logic [15:0] a, b, c, d, input logic [2:0] nop_code);
        for (int i = 0; i < 256; i++) mem[i] = '0;
        mem[0]  = ins(3'd1, 8'h80);
        mem[1]  = ins(3'd3, 8'h81);
        mem[2]  = ins(3'd3, 8'h82);
        mem[3]  = ins(nop_code, 8'h92);
        mem[4]  = ins(3'd2, 8'h90);
        mem[5]  = ins(3'd1, 8'h83);
        mem[6]  = ins(3'd3, 8'h83);
        mem[7]  = ins(3'd2, 8'h91);
        mem[8]  = ins(3'd4, 8'h0A);
        mem[9]  = ins(3'd2, 8'h92);
        mem[10] = ins(3'd4, 8'h0A);
        mem[8'h40] = ins(3'd1, 8'hA0);
        mem[8'h41] = ins(3'd3, 8'hA1);
        mem[8'h42] = ins(3'd2, 8'hA0);
        mem[8'h43] = ins(3'd5, 8'h00);
        mem[8'h80] = a; mem[8'h81] = b; mem[8'h82] = c; mem[8'h83] = d;
        mem[8'hA1] = 16'd1;
    endtask

    task automatic run_round(input logic [15:0] a, b, c, d, input logic [2:0] nop_code,
                             input bit use_irq, input bit en, input int irq_at,
                             input int hold, input bit timing);
        int waited;
        load_prog(a, b, c, d, nop_code);
        irq = 1'b0;
        irq_en = en;
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 reset pc", pc, 0);
        chk("R1 reset acc", acc, 0);
        chk("R1 reset handler", in_h, 0);
        chk("R1 reset no write", mem_wr, 0);
        rst_n = 1'b1;
        if (timing) begin
            chk("R1 first read strobe", mem_rd, 1);
            chk("R1 first address", mem_addr, 0);
            @(negedge clk);
            chk("R2 data cycle no strobe", mem_rd, 0);
            @(negedge clk);
            chk("R3 pc after fetch", pc, 1);
            chk("R4 operand read strobe", mem_rd, 1);
            chk("R4 operand address", mem_addr, 8'h80);
            @(negedge clk);
            chk("R2 operand data cycle", mem_rd, 0);
            @(negedge clk);
            chk("R4 load result", acc, a);
        end
        repeat (irq_at) @(negedge clk);
        if (use_irq) begin
            irq = 1'b1;
            waited = 0;
            while (!in_h && waited < 40) begin
                @(negedge clk);
                waited++;
            end
            repeat (hold) @(negedge clk);
            irq = 1'b0;
        end
        repeat (200) @(negedge clk);
        chk("R4 sum stored", mem[8'h90], exp_sum3(a, b, c));
        chk("R5 double stored", mem[8'h91], exp_double(d));
        chk("R6 jump skipped store", mem[8'h92], 0);
        chk("R7 nop left word", mem[3], ins(nop_code, 8'h92));
        chk("R10 handler mark clear", in_h, 0);
        if (!use_irq)      chk("R8 no request no handler", mem[8'hA0], 0);
        else if (!en)      chk("R11 disabled request ignored", mem[8'hA0], 0);
        else if (hold > 0) chk("R9 single run while held", mem[8'hA0], 1);
        else               chk("R8 handler ran once", mem[8'hA0], 1);
    endtask

    initial begin
        int seed;
        seed = $urandom(32'd4711);
        run_round(16'h0011, 16'h0022, 16'h0033, 16'h0100, 3'd0, 0, 1, 0, 0, 1);
        run_round(16'hFFFF, 16'h0002, 16'h0001, 16'h8001, 3'd6, 1, 0, 5, 0, 0);
        run_round(16'h1234, 16'h1111, 16'h2222, 16'h0303, 3'd7, 1, 1, 0, 0, 0);
        run_round(16'h0A0A, 16'h0B0B, 16'h0C0C, 16'h7FFF, 3'd0, 1, 1, 12, 8, 0);
        run_round(16'h4000, 16'h4000, 16'h8000, 16'h0001, 3'd0, 1, 1, 60, 0, 0);
        for (int r = 0; r < 24; r++) begin
            logic [2:0] nc;
            nc = ($urandom % 3 == 0) ? 3'd0 : 3'($urandom % 2 + 6);
            run_round(16'($urandom), 16'($urandom), 16'($urandom), 16'($urandom), nc,
                      1, ($urandom % 4) != 0, $urandom % 55, ($urandom % 2) * 8, 0);
        end
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule